// File: doc/BRIEF.md
# Tagged Address Translation Cache

This block is a small fully associative translation cache. Each slot maps a virtual page number under one address-space identifier to a physical frame number. All slots are compared with the incoming page number and the current identifier at the same time. Hit, fault and the physical address are combinational outputs, available in the same cycle as the lookup. Because every slot carries its own identifier, translations from several processes can stay resident together, and a context switch only changes `cur_asid_i`.

On a miss the block raises `lkp_miss_o`. An external page-table walker then presents the translation on the fill port, and the block installs it at the next clock edge. Slot choice for a fill follows a fixed order:
1. a slot already holding the same page and identifier is rewritten;
2. otherwise the lowest-numbered empty slot is used;
3. otherwise the slot under a round-robin pointer is replaced.

The invalidate port clears either every slot, or only the slots belonging to one identifier, in a single cycle.

Top module: `asid_tlb`

## Requirements
- R1: With `lkp_valid_i` high, a resident slot whose page number equals `lkp_vpn_i`, whose identifier equals `cur_asid_i` and whose page-valid flag is set drives `lkp_hit_o` high in the same cycle. `lkp_paddr_o` then equals the stored frame number shifted left by OFF_W bits, OR the unchanged offset `lkp_off_i`.
- R2: A slot whose page number matches but whose identifier differs from `cur_asid_i` does not hit. Slots holding the same page under different identifiers each return their own frame.
- R3: With `lkp_valid_i` high and no matching slot, `lkp_miss_o` is high and `lkp_hit_o` and `lkp_fault_o` are low. With `lkp_valid_i` low, all three outputs are low. After reset every lookup misses.
- R4: A translation installed with `fill_pte_valid_i` low makes a matching lookup raise `lkp_fault_o`, with `lkp_hit_o` and `lkp_miss_o` low.
- R5: A fill becomes visible to lookups from the cycle after it is presented. While an empty slot exists, a fill evicts nothing.
- R6: When every slot is occupied, a fill for a new key replaces slots in round-robin order. The order starts at slot 0 after reset, and slots are numbered in order of first fill into an empty cache. The pointer advances only on such replacements.
- R7: A fill whose page and identifier are already resident rewrites that slot's frame and page-valid flag. It creates no duplicate and evicts nothing.
- R8: `inv_all_i` removes every translation at the next clock edge.
- R9: `inv_asid_val_i` removes, at the next clock edge, only the slots whose identifier equals `inv_asid_i`.
- R10: A fill presented in a cycle with any invalidate request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Virtual page number to translate |
| lkp_off_i | input | OFF_W | Page offset, passed through |
| cur_asid_i | input | ASID_W | Identifier of the running process |
| lkp_hit_o | output | 1 | Translation found and page valid |
| lkp_miss_o | output | 1 | No resident translation |
| lkp_fault_o | output | 1 | Translation found but page marked invalid |
| lkp_paddr_o | output | PFN_W+OFF_W | Physical address (frame, offset) |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Page number of the fill |
| fill_asid_i | input | ASID_W | Identifier of the fill |
| fill_pfn_i | input | PFN_W | Frame number of the fill |
| fill_pte_valid_i | input | 1 | Page-valid flag of the fill |
| inv_all_i | input | 1 | Remove all translations |
| inv_asid_val_i | input | 1 | Remove translations of one identifier |
| inv_asid_i | input | ASID_W | Identifier to remove |

## Verification
The assertions check four properties on every cycle:
- no two resident slots ever match one lookup key;
- hit, miss and fault are mutually exclusive and silent without a request;
- a flush leaves nothing that can hit;
- a fill never lowers occupancy, lands in an empty slot while one exists, and the replacement pointer moves only when the cache is full.

The bench scenarios must show the rest, because these behaviours span many cycles and need a model of the whole content:
- the round-robin victim order;
- in-place update of a resident key;
- identifier-selective flushing;
- dropping a fill that meets an invalidate;
- the exact physical address.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  // source of the slot chosen for a fill
  typedef enum logic [1:0] {
    PICK_NONE = 2'd0,
    PICK_SAME = 2'd1,
    PICK_FREE = 2'd2,
    PICK_RR   = 2'd3
  } pick_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned KEY_W   = 28
) (
  input  logic [ENTRIES-1:0][KEY_W-1:0] keys_i,
  input  logic [ENTRIES-1:0]            used_i,
  input  logic [KEY_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = used_i[g] && (keys_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick
  import asid_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ENTRIES-1:0] used_i,
  input  logic [ENTRIES-1:0] same_i,
  output logic [IDX_W-1:0]   slot_o,
  output pick_e              src_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] same_idx;

  always_comb begin
    free_idx = '0;
    same_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!used_i[i]) free_idx = IDX_W'(i);
      if (same_i[i])  same_idx = IDX_W'(i);
    end
  end

  always_comb begin
    src_o  = PICK_NONE;
    slot_o = ptr_q;
    if (req_i) begin
      if (|same_i) begin
        src_o  = PICK_SAME;
        slot_o = same_idx;
      end else if (!(&used_i)) begin
        src_o  = PICK_FREE;
        slot_o = free_idx;
      end else begin
        src_o  = PICK_RR;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (src_o == PICK_RR)
      ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + IDX_W'(1);
  end

  assert_rr_only_when_full_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr_q) |-> $past(&used_i));

  assert_free_slot_first_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(&used_i) && !(|same_i)) |-> !used_i[slot_o]);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned OFF_W   = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lkp_valid_i,
  input  logic [VPN_W-1:0]       lkp_vpn_i,
  input  logic [OFF_W-1:0]       lkp_off_i,
  input  logic [ASID_W-1:0]      cur_asid_i,
  output logic                   lkp_hit_o,
  output logic                   lkp_miss_o,
  output logic                   lkp_fault_o,
  output logic [PFN_W+OFF_W-1:0] lkp_paddr_o,
  input  logic                   fill_valid_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [ASID_W-1:0]      fill_asid_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic                   fill_pte_valid_i,
  input  logic                   inv_all_i,
  input  logic                   inv_asid_val_i,
  input  logic [ASID_W-1:0]      inv_asid_i
);
  localparam int unsigned KEY_W = VPN_W + ASID_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]              used_q, ok_q;
  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]   pfn_q;
  logic [ENTRIES-1:0][KEY_W-1:0]   keys;
  logic [ENTRIES-1:0]              lkp_match, fill_match;
  logic [IDX_W-1:0]                fill_slot;
  pick_e                           fill_src;
  logic                            fill_go;
  logic                            any_match, sel_ok;
  logic [PFN_W-1:0]                sel_pfn;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_key
    assign keys[g] = {asid_q[g], vpn_q[g]};
  end

  tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lkp_cam (
    .keys_i (keys),
    .used_i (used_q),
    .key_i  ({cur_asid_i, lkp_vpn_i}),
    .match_o(lkp_match)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_fill_cam (
    .keys_i (keys),
    .used_i (used_q),
    .key_i  ({fill_asid_i, fill_vpn_i}),
    .match_o(fill_match)
  );

  // invalidation dominates a fill in the same cycle
  assign fill_go = fill_valid_i && !inv_all_i && !inv_asid_val_i;

  tlb_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (fill_go),
    .used_i(used_q),
    .same_i(fill_match),
    .slot_o(fill_slot),
    .src_o (fill_src)
  );

  // match vector is one-hot at most, so an OR-mux suffices
  always_comb begin
    sel_pfn = '0;
    sel_ok  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_match[i]) begin
        sel_pfn = sel_pfn | pfn_q[i];
        sel_ok  = sel_ok | ok_q[i];
      end
    end
  end

  assign any_match   = |lkp_match;
  assign lkp_hit_o   = lkp_valid_i && any_match && sel_ok;
  assign lkp_fault_o = lkp_valid_i && any_match && !sel_ok;
  assign lkp_miss_o  = lkp_valid_i && !any_match;
  assign lkp_paddr_o = {sel_pfn, lkp_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
      ok_q   <= '0;
      vpn_q  <= '0;
      asid_q <= '0;
      pfn_q  <= '0;
    end else if (inv_all_i) begin
      used_q <= '0;
    end else if (inv_asid_val_i) begin
      for (int i = 0; i < ENTRIES; i++)
        if (asid_q[i] == inv_asid_i) used_q[i] <= 1'b0;
    end else if (fill_go && fill_src != PICK_NONE) begin
      used_q[fill_slot] <= 1'b1;
      ok_q[fill_slot]   <= fill_pte_valid_i;
      vpn_q[fill_slot]  <= fill_vpn_i;
      asid_q[fill_slot] <= fill_asid_i;
      pfn_q[fill_slot]  <= fill_pfn_i;
    end
  end

  assert_single_match_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match));

  assert_outputs_exclusive_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lkp_hit_o, lkp_miss_o, lkp_fault_o}));

  assert_idle_silent_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !(lkp_hit_o || lkp_miss_o || lkp_fault_o));

  assert_flush_empties_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !lkp_hit_o && !lkp_fault_o);

  assert_fill_keeps_count_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_go |=> $countones(used_q) >= $past($countones(used_q)));
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [19:0] lkp_vpn_i = '0;
  logic [11:0] lkp_off_i = '0;
  logic [7:0]  cur_asid_i = '0;
  logic        lkp_hit_o, lkp_miss_o, lkp_fault_o;
  logic [31:0] lkp_paddr_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [7:0]  fill_asid_i = '0;
  logic [19:0] fill_pfn_i = '0;
  logic        fill_pte_valid_i = 1'b0;
  logic        inv_all_i = 1'b0;
  logic        inv_asid_val_i = 1'b0;
  logic [7:0]  inv_asid_i = '0;

  int checks = 0;
  int fails  = 0;

  // bench model of the content, built from the requirements
  bit          m_used [N];
  bit          m_ok   [N];
  logic [19:0] m_vpn  [N];
  logic [7:0]  m_asid [N];
  logic [19:0] m_pfn  [N];
  int          m_ptr = 0;

  always #4 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid_i), .lkp_vpn_i(lkp_vpn_i), .lkp_off_i(lkp_off_i),
    .cur_asid_i(cur_asid_i), .lkp_hit_o(lkp_hit_o), .lkp_miss_o(lkp_miss_o),
    .lkp_fault_o(lkp_fault_o), .lkp_paddr_o(lkp_paddr_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_asid_i(fill_asid_i),
    .fill_pfn_i(fill_pfn_i), .fill_pte_valid_i(fill_pte_valid_i),
    .inv_all_i(inv_all_i), .inv_asid_val_i(inv_asid_val_i), .inv_asid_i(inv_asid_i)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                    input bit ok, input bit fv, input bit iall, input bit iav,
                    input logic [7:0] ia);
    int same;
    int free;
    @(negedge clk);
    fill_valid_i = fv; fill_vpn_i = v; fill_asid_i = a; fill_pfn_i = p;
    fill_pte_valid_i = ok; inv_all_i = iall; inv_asid_val_i = iav; inv_asid_i = ia;
    if (iall) begin
      for (int i = 0; i < N; i++) m_used[i] = 0;
    end else if (iav) begin
      for (int i = 0; i < N; i++) if (m_asid[i] == ia) m_used[i] = 0;
    end else if (fv) begin
      same = -1; free = -1;
      for (int i = N - 1; i >= 0; i--) begin
        if (m_used[i] && m_vpn[i] == v && m_asid[i] == a) same = i;
        if (!m_used[i]) free = i;
      end
      if (same < 0 && free >= 0) same = free;
      if (same < 0) begin
        same = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_used[same] = 1; m_ok[same] = ok; m_vpn[same] = v;
      m_asid[same] = a; m_pfn[same] = p;
    end
    @(posedge clk);
    #1;
    fill_valid_i = 0; inv_all_i = 0; inv_asid_val_i = 0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p, input bit ok);
    op(v, a, p, ok, 1'b1, 1'b0, 1'b0, 8'h0);
  endtask

  task automatic lookup(input string tag, input logic [19:0] v, input logic [7:0] a,
                        input logic [11:0] off);
    int k;
    @(negedge clk);
    lkp_valid_i = 1; lkp_vpn_i = v; cur_asid_i = a; lkp_off_i = off;
    #1;
    k = -1;
    for (int i = 0; i < N; i++) if (m_used[i] && m_vpn[i] == v && m_asid[i] == a) k = i;
    if (k < 0) begin
      check({tag, " miss"}, {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b010);
    end else if (!m_ok[k]) begin
      check({tag, " fault"}, {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b001);
    end else begin
      check({tag, " hit"}, {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b100);
      check({tag, " paddr"}, lkp_paddr_o, 64'(m_pfn[k]) * 4096 + 64'(off));
    end
    lkp_valid_i = 0;
  endtask

  task automatic sweep(input string tag, input int salt);
    for (int i = 0; i < N; i++) begin
      lookup(tag, m_vpn[i], m_asid[i], 12'((i * 331 + salt) % 4096));
      lookup({tag, " R2 other-id"}, m_vpn[i], m_asid[i] ^ 8'h40, 12'(i));
    end
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_used[i] = 0; m_ok[i] = 0; m_vpn[i] = '0; m_asid[i] = '0; m_pfn[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R3: reset state, idle silence
    #1;
    check("R3 idle", {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b000);
    lookup("R3 after reset", 20'h00000, 8'h00, 12'h000);
    lookup("R3 after reset", 20'h00123, 8'h01, 12'hfff);

    // R1 R5: fill every empty slot, nothing evicted
    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), 8'h01, 20'h500 + 20'(i * 3), 1'b1);
    sweep("R1 R5 full", 7);
    lookup("R3 absent", 20'h999, 8'h01, 12'h010);

    // R6: round-robin replacement starting at slot 0
    fill(20'h200, 8'h01, 20'hABCDE, 1'b1);
    lookup("R6 first victim", 20'h100, 8'h01, 12'h001);
    lookup("R6 new entry", 20'h200, 8'h01, 12'h123);
    fill(20'h201, 8'h01, 20'h0F0F0, 1'b1);
    lookup("R6 second victim", 20'h101, 8'h01, 12'h002);
    sweep("R6 after", 11);

    // R7: refill of a resident key updates in place
    fill(20'h105, 8'h01, 20'h77777, 1'b1);
    lookup("R7 updated", 20'h105, 8'h01, 12'h456);
    sweep("R7 no eviction", 13);

    // R4: entry with page-valid flag cleared faults
    fill(20'h300, 8'h03, 20'h12345, 1'b0);
    lookup("R4 fault", 20'h300, 8'h03, 12'h000);
    fill(20'h300, 8'h03, 20'h12345, 1'b1);
    lookup("R4 R7 revalidated", 20'h300, 8'h03, 12'h0aa);

    // R9: flush one identifier only
    fill(20'h301, 8'h03, 20'h54321, 1'b1);
    op(20'h0, 8'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
    lookup("R9 cleared", 20'h300, 8'h03, 12'h000);
    lookup("R9 cleared", 20'h301, 8'h03, 12'h000);
    sweep("R9 others kept", 17);
    fill(20'h400, 8'h05, 20'h40404, 1'b1);
    sweep("R5 freed slot reused", 19);

    // R10: fill dropped when an invalidate arrives in the same cycle
    op(20'h500, 8'h06, 20'h11111, 1'b1, 1'b1, 1'b0, 1'b1, 8'h05);
    lookup("R10 dropped fill", 20'h500, 8'h06, 12'h000);
    lookup("R9 R10 id cleared", 20'h400, 8'h05, 12'h000);
    op(20'h501, 8'h06, 20'h22222, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    lookup("R10 dropped fill", 20'h501, 8'h06, 12'h000);

    // R8: flush all
    sweep("R8 flushed", 23);

    // R2: same page under every identifier, each returns its own frame
    for (int a = 0; a < N; a++) fill(20'h0AAAA, 8'(a * 17), 20'(a * 4099 + 5), 1'b1);
    for (int a = 0; a < N; a++) lookup("R2 per-id frame", 20'h0AAAA, 8'(a * 17), 12'(a * 509));
    lookup("R2 unknown id", 20'h0AAAA, 8'hFE, 12'h000);
    sweep("R2 sweep", 29);

    // R5: lookup in the fill cycle still sees old content
    @(negedge clk);
    fill_valid_i = 1; fill_vpn_i = 20'h0BBBB; fill_asid_i = 8'h11; fill_pfn_i = 20'h1;
    fill_pte_valid_i = 1;
    lkp_valid_i = 1; lkp_vpn_i = 20'h0BBBB; cur_asid_i = 8'h11;
    #1;
    check("R5 not yet visible", {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b010);
    @(negedge clk);
    fill_valid_i = 0;
    #1;
    check("R5 visible next cycle", {lkp_hit_o, lkp_miss_o, lkp_fault_o}, 3'b100);
    lkp_valid_i = 0;

    finish_run();
  end
endmodule